// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block lets a synchronous host reach an external asynchronous static RAM of 131072 words of 16 bits. The RAM has one enable for each 8-bit byte lane. The host issues one request at a time over a valid/ready handshake. Each request carries a write flag, a 17-bit word address, 16 bits of write data and a 2-bit lane mask. The controller turns the request into a sequence of active-low memory strobes. That sequence is timed by a wait count (`cfg_wait`), which is sampled when the request is accepted. Read results come back on a single-cycle response pulse.

A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Once a request is accepted, `req_ready` stays low until the memory cycle and one turnaround cycle have finished. The host applies back-pressure only by holding `req_valid` low, and the response side has no stall input: `rsp_valid` is a one-cycle pulse that the host must take. The memory data bus is split into an output value, an input value and an output enable, which together form the tri-state control. The wait count is chosen so that the cycles spent with strobes asserted cover the 55 ns or 70 ns access time of the RAM at the host clock rate.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1, `mem_cen_n`, `mem_oen_n` and `mem_wen_n` are 1, `mem_lane_n` is 2'b11, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: During a read, `mem_cen_n` and `mem_oen_n` are held low with `mem_wen_n` high for exactly W cycles, where W is `cfg_wait` at acceptance. Mask bit 0 drives lane enable `mem_lane_n[0]` (data bits 7:0) low, and mask bit 1 drives `mem_lane_n[1]` (bits 15:8) low.
- R3: Read data is sampled on the last of the W cycles. `rsp_valid` is high for exactly the following cycle and carries that data on `rsp_rdata`; lanes whose mask bit is 0 read as 8'h00.
- R4: A write takes one setup cycle (chip enable low, write enable high, bus driven), then W cycles with `mem_wen_n` low, then one hold cycle with `mem_wen_n` high while chip enable stays low and the bus stays driven. Chip enable and the bus are released only after that. Only the lanes whose mask bit is set are written.
- R5: `mem_dq_oe` and a low `mem_oen_n` are never present together.
- R6: `mem_addr`, `mem_lane_n` and `mem_dq_out` do not change while `mem_wen_n` is low or on the cycle it rises.
- R7: A request with mask 2'b00 asserts no memory strobe. As a read it produces `rsp_valid` one cycle after acceptance with `rsp_rdata` = 16'h0000. As a write it produces no response.
- R8: `req_ready` is low from acceptance until the end of one turnaround cycle after the memory cycle: W+1 cycles for a read, W+3 for a write and 1 for a request with mask 2'b00.
- R9: A `cfg_wait` of 0 behaves as 1, and changes to `cfg_wait` after acceptance do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait | input | 4 | Strobe wait cycles (0 treated as 1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_cen_n | output | 1 | Chip enable, active low |
| mem_oen_n | output | 1 | Output enable, active low |
| mem_wen_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Byte lane enables, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The write and read patterns cover full-word, lower-only and upper-only masks to different addresses. A read of a lane that was never written proves that merging is done per lane and not per word. The memory model drives a fixed pattern on lanes that are not enabled, which separates correct masking of read data from passing the bus straight through. Wait counts of 0, 1, 3 and 7 are used, together with a change to `cfg_wait` during a busy cycle, to tell an exact strobe width apart from an off-by-one error or from the count being sampled late. Requests with mask 2'b00, requests to the highest address and back-to-back reads check the zero-strobe path, the full address width and the turnaround cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RD    = 3'd1,
    S_WSET  = 3'd2,
    S_WPUL  = 3'd3,
    S_WHOLD = 3'd4,
    S_TURN  = 3'd5
  } ctl_state_e;
endpackage

// File: rtl/sram_ctl_wait_cnt.sv
module sram_ctl_wait_cnt #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [WW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= WW'(1);
    else if (load)
      cnt <= (load_val == '0) ? WW'(1) : load_val;
    else if (dec && cnt > WW'(1))
      cnt <= cnt - WW'(1);
  end

  assign last = (cnt == WW'(1));
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       mask_zero,
  input  logic       last,
  output ctl_state_e st,
  output logic       accept,
  output logic       cnt_dec,
  output logic       capture,
  output logic       clear
);
  ctl_state_e nxt;

  always_comb begin
    nxt     = st;
    accept  = 1'b0;
    cnt_dec = 1'b0;
    capture = 1'b0;
    clear   = 1'b0;
    case (st)
      S_IDLE: if (req_valid) begin
        accept = 1'b1;
        if (mask_zero) begin
          nxt   = S_TURN;
          clear = !req_write;
        end else begin
          nxt = req_write ? S_WSET : S_RD;
        end
      end
      S_RD: begin
        cnt_dec = 1'b1;
        if (last) begin
          capture = 1'b1;
          nxt     = S_TURN;
        end
      end
      S_WSET:  nxt = S_WPUL;
      S_WPUL: begin
        cnt_dec = 1'b1;
        if (last) nxt = S_WHOLD;
      end
      S_WHOLD: nxt = S_TURN;
      S_TURN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
  parameter int DW    = 16,
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [LANES-1:0] mask,
  input  logic             capture,
  input  logic             clear,
  input  logic [DW-1:0]    dq_in,
  output logic [LANES-1:0] sel_n,
  output logic [DW-1:0]    rdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sel_n[i] = !(active && mask[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rdata[i*8 +: 8] <= '0;
      else if (clear)
        rdata[i*8 +: 8] <= '0;
      else if (capture)
        rdata[i*8 +: 8] <= mask[i] ? dq_in[i*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW    = 17,
  parameter int DW    = 16,
  parameter int WW    = 4,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WW-1:0]    cfg_wait,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_mask,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_cen_n,
  output logic             mem_oen_n,
  output logic             mem_wen_n,
  output logic [LANES-1:0] mem_lane_n,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in
);
  ctl_state_e       st;
  logic             accept, cnt_dec, capture, clear, last;
  logic [AW-1:0]    c_addr;
  logic [DW-1:0]    c_wdata;
  logic [LANES-1:0] c_mask;
  logic             active;

  sram_ctl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .mask_zero (req_mask == '0),
    .last      (last),
    .st        (st),
    .accept    (accept),
    .cnt_dec   (cnt_dec),
    .capture   (capture),
    .clear     (clear)
  );

  sram_ctl_wait_cnt #(.WW(WW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cfg_wait),
    .dec      (cnt_dec),
    .last     (last)
  );

  // Command held from acceptance until the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_addr  <= '0;
      c_wdata <= '0;
      c_mask  <= '0;
    end else if (accept) begin
      c_addr  <= req_addr;
      c_wdata <= req_wdata;
      c_mask  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= capture | clear;
  end

  assign active = (st == S_RD) || (st == S_WSET) || (st == S_WPUL) || (st == S_WHOLD);

  sram_ctl_lanes #(.DW(DW), .LANES(LANES)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .mask    (c_mask),
    .capture (capture),
    .clear   (clear),
    .dq_in   (mem_dq_in),
    .sel_n   (mem_lane_n),
    .rdata   (rsp_rdata)
  );

  assign req_ready  = (st == S_IDLE);
  assign mem_addr   = c_addr;
  assign mem_dq_out = c_wdata;
  assign mem_cen_n  = !active;
  assign mem_oen_n  = (st != S_RD);
  assign mem_wen_n  = (st != S_WPUL);
  assign mem_dq_oe  = (st == S_WSET) || (st == S_WPUL) || (st == S_WHOLD);
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW    = 17,
  parameter int DW    = 16,
  parameter int WW    = 4,
  localparam int LANES = DW / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WW-1:0]    cfg_wait,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [DW-1:0]    req_wdata,
  input logic [LANES-1:0] req_mask,
  input logic             rsp_valid,
  input logic [DW-1:0]    rsp_rdata,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_cen_n,
  input logic             mem_oen_n,
  input logic             mem_wen_n,
  input logic [LANES-1:0] mem_lane_n,
  input logic [DW-1:0]    mem_dq_out,
  input logic             mem_dq_oe,
  input logic [DW-1:0]    mem_dq_in
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cen_n && mem_oen_n && mem_wen_n && !mem_dq_oe && mem_lane_n == '1));

  assert_rd_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oen_n |-> (!mem_cen_n && mem_wen_n));

  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_wr_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wen_n) |-> ($past(!mem_cen_n) && $past(mem_dq_oe) && $stable(mem_addr)));

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wen_n) |-> (!mem_cen_n && mem_dq_oe));

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oen_n));

  assert_wr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mem_wen_n)) |-> ($stable(mem_addr) && $stable(mem_lane_n) && $stable(mem_dq_out)));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cen_n |-> !req_ready);
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW), .WW(WW)) chk_i (.*);

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_wait = 4'd1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_cen_n, mem_oen_n, mem_wen_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out, mem_dq_in;

  int total = 0, bad = 0;
  int cen_cycles = 0;
  int exp_pulse = 1;
  logic [1:0] exp_sel = 2'b11;
  logic [15:0] sram   [logic [16:0]];
  logic [15:0] shadow [logic [16:0]];
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cen_n(mem_cen_n), .mem_oen_n(mem_oen_n),
    .mem_wen_n(mem_wen_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Asynchronous memory model: write ends on the rise of write enable
  always @(posedge mem_wen_n) begin
    if (rst_n && !mem_cen_n) begin
      logic [15:0] v;
      v = sram.exists(mem_addr) ? sram[mem_addr] : 16'h0000;
      if (!mem_lane_n[0]) v[7:0]  = mem_dq_oe ? mem_dq_out[7:0]  : 8'hEE;
      if (!mem_lane_n[1]) v[15:8] = mem_dq_oe ? mem_dq_out[15:8] : 8'hEE;
      sram[mem_addr] = v;
    end
  end

  always_comb begin
    logic [15:0] s;
    s = sram.exists(mem_addr) ? sram[mem_addr] : 16'h0000;
    mem_dq_in = 16'hA5A5;
    if (!mem_cen_n && !mem_oen_n && mem_wen_n) begin
      if (!mem_lane_n[0]) mem_dq_in[7:0]  = s[7:0];
      if (!mem_lane_n[1]) mem_dq_in[15:8] = s[15:8];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: strobe widths, response scoreboard, setup/hold shape
  int rd_run = 0, wr_run = 0;
  logic prev_wen = 1'b1, prev_cen = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!mem_cen_n) cen_cycles++;
    if (mem_dq_oe && !mem_oen_n) check("R5 contention", 1, 0);
    if (!mem_oen_n) begin
      rd_run++;
      if (rd_run == 1) check("R2 read lane enables", {30'd0, mem_lane_n}, {30'd0, exp_sel});
    end else if (rd_run != 0) begin
      check("R2 read strobe width", rd_run, exp_pulse);
      rd_run = 0;
    end
    if (!mem_wen_n) begin
      wr_run++;
      if (prev_wen) check("R4 setup before write pulse", {prev_cen, prev_oe}, 2'b01);
    end else if (wr_run != 0) begin
      check("R4 write pulse width", wr_run, exp_pulse);
      check("R4 R6 hold cycle cen/oe", {mem_cen_n, mem_dq_oe}, 2'b01);
      wr_run = 0;
    end
    if (rsp_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected response", 1, 0);
      else check("R3 R7 read data", rsp_rdata, exp_q.pop_front());
    end
    prev_wen = mem_wen_n; prev_cen = mem_cen_n; prev_oe = mem_dq_oe;
  end

  // Driver: issues one request, records expectations, checks busy window
  task automatic do_req(input logic w, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] m, input logic [3:0] wt);
    int n, busy, cen0;
    logic [15:0] s;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n = (wt == 0) ? 1 : int'(wt);
    exp_pulse = n;
    exp_sel = ~m;
    s = shadow.exists(a) ? shadow[a] : 16'h0000;
    if (w) begin
      if (m[0]) s[7:0]  = d[7:0];
      if (m[1]) s[15:8] = d[15:8];
      shadow[a] = s;
    end else begin
      exp_q.push_back({m[1] ? s[15:8] : 8'h00, m[0] ? s[7:0] : 8'h00});
    end
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    cfg_wait = wt;
    cen0 = cen_cycles;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = 16'h5A5A; req_addr = 17'h0AAAA; req_mask = 2'b11;
    cfg_wait = 4'hF; // R9: changes after acceptance are ignored
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
    if (m == 2'b00) begin
      check("R8 busy cycles zero mask", busy, 1);
      check("R7 no strobe for zero mask", cen_cycles - cen0, 0);
    end else
      check("R8 busy cycles", busy, w ? n + 3 : n + 1);
  endtask

  initial begin
    int cyc = 0;
    while (1) begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready, 1);
    check("R1 reset strobes", {mem_cen_n, mem_oen_n, mem_wen_n, mem_lane_n, mem_dq_oe, rsp_valid}, 7'b1111100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {req_ready, mem_cen_n, mem_dq_oe}, 3'b110);

    do_req(1, 17'h00010, 16'hBEEF, 2'b11, 4'd3);   // R4 full write
    do_req(0, 17'h00010, 16'h0000, 2'b11, 4'd3);   // R2 R3 read back
    do_req(1, 17'h00020, 16'h1234, 2'b01, 4'd1);   // R4 lower lane only
    do_req(0, 17'h00020, 16'h0000, 2'b11, 4'd2);   // upper lane never written
    do_req(1, 17'h00030, 16'hCAFE, 2'b10, 4'd0);   // R9 zero wait = 1
    do_req(0, 17'h00030, 16'h0000, 2'b10, 4'd0);   // R3 masked lane reads 0
    do_req(0, 17'h00010, 16'h0000, 2'b01, 4'd7);   // R2 lower lane only
    do_req(1, 17'h1FFFF, 16'h8001, 2'b11, 4'd2);   // top address
    do_req(0, 17'h1FFFF, 16'h0000, 2'b11, 4'd2);
    do_req(1, 17'h00010, 16'h0000, 2'b00, 4'd3);   // R7 zero-mask write
    do_req(0, 17'h00010, 16'h0000, 2'b00, 4'd3);   // R7 zero-mask read -> 0
    do_req(0, 17'h00010, 16'h0000, 2'b11, 4'd1);   // data unchanged by R7 write
    do_req(0, 17'h00020, 16'h0000, 2'b01, 4'd1);   // back-to-back reads
    repeat (4) @(negedge clk);
    check("R3 all responses seen", exp_q.size(), 0);
    check("R1 idle at end", {req_ready, mem_cen_n, mem_oen_n, mem_wen_n, mem_dq_oe}, 5'b11110);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule